// File: doc/BRIEF.md
# Start-up Delay Sequencer

This block keeps the core stopped, with its clock gated off and its internal reset held, until the start-up time chosen by two static configuration codes has passed. It runs in two situations: after power-on or an external reset request, and on return from deep sleep. The return from sleep is short and fixed. The reset sequence first counts a fixed number of main-clock cycles. When an external clock is selected, it can then add a delay of milliseconds that is counted on a slow, always-running timing clock (128 kHz nominal).

A 4-bit clock-source code and a 2-bit start-up code set the reset delay. The full delay table applies only when the clock-source code selects the external clock. Any other clock source uses a fixed short delay. One start-up code value is not a valid setting. With that value the block never releases the core and raises an error flag. A 2-bit status records which path brought the core up last. It keeps its value across reset requests and is cleared only by power-on.

Top module: `sdseq_top`

## Requirements
- R1: While `por_n` is low, `core_clk_en`, `core_rst_rel` and `cfg_err` are 0 and `last_path` is 2'b00.
- R2: With `cksel_code` 4'b0000 and `sut_code` 2'b00, the core is released 14 main cycles after the reset start. Both outputs rise after the 14th rising edge that follows the edge sampling `rst_req` (or that follows `por_n` release), and `last_path` becomes 2'b01.
- R3: With `cksel_code` 4'b0000 and `sut_code` 2'b01, release follows the 14 main cycles plus `SLOW_SHORT` slow-clock cycles, and `last_path` becomes 2'b01.
- R4: With `cksel_code` 4'b0000 and `sut_code` 2'b10, release follows the 14 main cycles plus `SLOW_LONG` slow-clock cycles, and `last_path` becomes 2'b01.
- R5: With `cksel_code` 4'b0000 and `sut_code` 2'b11, `cfg_err` rises after the 14 main cycles. The core stays held until the next reset, and `last_path` keeps its value.
- R6: With any `cksel_code` other than 4'b0000, release comes 14 main cycles after the reset start for every `sut_code`, including 2'b11 with no error, and `last_path` becomes 2'b10.
- R7: When `deep_sleep` is high while running, `core_clk_en` drops and `core_rst_rel` stays 1. After `deep_sleep` is sampled low, `core_clk_en` returns 6 cycles later for any `sut_code`, and `last_path` becomes 2'b11.
- R8: An `rst_req` sampled high in any phase drops `core_rst_rel`, `core_clk_en` and `cfg_err` at that edge and restarts the whole sequence from its first cycle.
- R9: `last_path` changes only when the core clock is enabled, and it keeps its value across `rst_req`.
- R10: `deep_sleep` has no effect while the core is held (counting, slow wait, error state). It takes effect only once the core is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock |
| clk_slow | input | 1 | Slow timing clock, time base for millisecond delays |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Synchronous external reset request, active high |
| deep_sleep | input | 1 | Sleep request level; its falling edge starts the wake sequence |
| sut_code | input | 2 | Static start-up delay select |
| cksel_code | input | 4 | Static clock-source select; 4'b0000 = external clock |
| core_clk_en | output | 1 | Enable for the core clock gate |
| core_rst_rel | output | 1 | 1 = internal reset released |
| cfg_err | output | 1 | Reserved start-up code detected, core kept in reset |
| last_path | output | 2 | Path completed last: 00 none, 01 table, 10 bypass, 11 wake |

## Verification
A behavioural model in the bench follows every clock and is compared on every clock. It runs each start-up code with the external clock, and then the bypass clock source with the reserved code. This separates the exact 14-cycle release, the two slow-clock delays and the error hold. The slow delays are checked against a window of cycles. The window's lower bound tells the short delay from the long one even after the clock-domain crossing. Sleep requests arrive while running, during the slow wait, during the error hold and across a whole boot. This shows whether the 6-cycle wake path is independent of the start-up code, and whether `deep_sleep` is ignored while the core is held. Reset requests arrive during the slow wait and during the main-cycle count, and show whether restart begins from the first cycle and whether the path status survives the reset.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned CKSEL_W = 4;
  localparam int unsigned SUT_W   = 2;

  typedef enum logic [2:0] {
    ST_BOOT, ST_SLOW, ST_RUN, ST_SLEEP, ST_WAKE, ST_HALT
  } seq_state_t;

  typedef enum logic [1:0] {
    PATH_NONE   = 2'b00,
    PATH_TABLE  = 2'b01,
    PATH_BYPASS = 2'b10,
    PATH_WAKE   = 2'b11
  } path_t;

  typedef enum logic [1:0] {
    EXIT_TABLE, EXIT_BYPASS, EXIT_SLOW, EXIT_FAULT
  } boot_exit_t;

  // Decide where the main-cycle phase of a reset sequence leads.
  function automatic boot_exit_t boot_exit_kind(input logic [CKSEL_W-1:0] cksel,
                                                input logic [SUT_W-1:0]   sut);
    if (cksel != '0) return EXIT_BYPASS;
    case (sut)
      2'b00:   return EXIT_TABLE;
      2'b11:   return EXIT_FAULT;
      default: return EXIT_SLOW;
    endcase
  endfunction

  // Number of slow-clock cycles of the millisecond phase.
  function automatic int unsigned slow_cycles(input logic [SUT_W-1:0] sut,
                                              input int unsigned short_c,
                                              input int unsigned long_c);
    return (sut == 2'b10) ? long_c : short_c;
  endfunction
endpackage

// File: rtl/sdseq_sync2.sv
module sdseq_sync2 #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  timeunit 1ns; timeprecision 1ps;

  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sdseq_slow_timer.sv
module sdseq_slow_timer
  import sdseq_pkg::*;
#(
  parameter int unsigned SLOW_SHORT = 512,
  parameter int unsigned SLOW_LONG  = 8192
) (
  input  logic             clk_slow,
  input  logic             por_n,
  input  logic             go_async,
  input  logic [SUT_W-1:0] sut_code,
  output logic             ack,
  output logic             done
);
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned MAXC = (SLOW_LONG > SLOW_SHORT) ? SLOW_LONG : SLOW_SHORT;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic          go_s;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;

  sdseq_sync2 #(.WIDTH(1)) go_sync_i (
    .clk   (clk_slow),
    .rst_n (por_n),
    .d     (go_async),
    .q     (go_s)
  );

  assign last_idx = CW'(slow_cycles(sut_code, SLOW_SHORT, SLOW_LONG) - 1);

  always_ff @(posedge clk_slow or negedge por_n) begin
    if (!por_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!go_s) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == last_idx) done <= 1'b1;
      else                 cnt  <= cnt + 1'b1;
    end
  end

  assign ack = go_s;
endmodule

// File: rtl/sdseq_fsm.sv
module sdseq_fsm
  import sdseq_pkg::*;
#(
  parameter int unsigned BOOT_CYCLES = 14,
  parameter int unsigned WAKE_CYCLES = 6
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_req,
  input  logic               deep_sleep,
  input  logic [SUT_W-1:0]   sut_code,
  input  logic [CKSEL_W-1:0] cksel_code,
  input  logic               ack_s,
  input  logic               done_s,
  output logic               go,
  output logic               clk_en,
  output logic               rst_rel,
  output logic               err,
  output logic [1:0]         path,
  output logic               boot_exit_ev,
  output logic               wake_exit_ev
);
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned MAXC  = (BOOT_CYCLES > WAKE_CYCLES) ? BOOT_CYCLES : WAKE_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] BOOT_LAST = CNT_W'(BOOT_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYCLES - 1);

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  path_t            path_q;
  boot_exit_t       kind;

  assign kind         = boot_exit_kind(cksel_code, sut_code);
  // The slow side must have seen the previous request withdrawn first.
  assign boot_exit_ev = (st == ST_BOOT) && (cnt == BOOT_LAST) && !ack_s && !done_s;
  assign wake_exit_ev = (st == ST_WAKE) && (cnt == WAKE_LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st     <= ST_BOOT;
      cnt    <= '0;
      go     <= 1'b0;
      path_q <= PATH_NONE;
    end else if (rst_req) begin
      st  <= ST_BOOT;
      cnt <= '0;
      go  <= 1'b0;
    end else begin
      unique case (st)
        ST_BOOT: begin
          if (boot_exit_ev) begin
            cnt <= '0;
            unique case (kind)
              EXIT_TABLE:  begin st <= ST_RUN; path_q <= PATH_TABLE;  end
              EXIT_BYPASS: begin st <= ST_RUN; path_q <= PATH_BYPASS; end
              EXIT_SLOW:   begin st <= ST_SLOW; go <= 1'b1; end
              EXIT_FAULT:  st <= ST_HALT;
              default:     st <= ST_HALT;
            endcase
          end else if (cnt != BOOT_LAST) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SLOW: begin
          if (done_s) begin
            st     <= ST_RUN;
            go     <= 1'b0;
            path_q <= PATH_TABLE;
          end
        end
        ST_RUN:   if (deep_sleep) st <= ST_SLEEP;
        ST_SLEEP: begin
          if (!deep_sleep) begin
            st  <= ST_WAKE;
            cnt <= '0;
          end
        end
        ST_WAKE: begin
          if (wake_exit_ev) begin
            st     <= ST_RUN;
            cnt    <= '0;
            path_q <= PATH_WAKE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HALT: st <= ST_HALT;
        default: st <= ST_BOOT;
      endcase
    end
  end

  assign clk_en  = (st == ST_RUN);
  assign rst_rel = (st == ST_RUN) || (st == ST_SLEEP) || (st == ST_WAKE);
  assign err     = (st == ST_HALT);
  assign path    = path_q;
endmodule

// File: rtl/sdseq_top.sv
module sdseq_top
  import sdseq_pkg::*;
#(
  parameter int unsigned BOOT_CYCLES = 14,
  parameter int unsigned WAKE_CYCLES = 6,
  parameter int unsigned SLOW_SHORT  = 512,
  parameter int unsigned SLOW_LONG   = 8192
) (
  input  logic       clk_main,
  input  logic       clk_slow,
  input  logic       por_n,
  input  logic       rst_req,
  input  logic       deep_sleep,
  input  logic [1:0] sut_code,
  input  logic [3:0] cksel_code,
  output logic       core_clk_en,
  output logic       core_rst_rel,
  output logic       cfg_err,
  output logic [1:0] last_path
);
  timeunit 1ns; timeprecision 1ps;

  logic       slow_go;
  logic       slow_ack;
  logic       slow_done;
  logic [1:0] back_s;
  logic       boot_exit_ev;
  logic       wake_exit_ev;

  sdseq_slow_timer #(
    .SLOW_SHORT (SLOW_SHORT),
    .SLOW_LONG  (SLOW_LONG)
  ) slow_i (
    .clk_slow (clk_slow),
    .por_n    (por_n),
    .go_async (slow_go),
    .sut_code (sut_code),
    .ack      (slow_ack),
    .done     (slow_done)
  );

  sdseq_sync2 #(.WIDTH(2)) back_sync_i (
    .clk   (clk_main),
    .rst_n (por_n),
    .d     ({slow_ack, slow_done}),
    .q     (back_s)
  );

  sdseq_fsm #(
    .BOOT_CYCLES (BOOT_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) fsm_i (
    .clk          (clk_main),
    .por_n        (por_n),
    .rst_req      (rst_req),
    .deep_sleep   (deep_sleep),
    .sut_code     (sut_code),
    .cksel_code   (cksel_code),
    .ack_s        (back_s[1]),
    .done_s       (back_s[0]),
    .go           (slow_go),
    .clk_en       (core_clk_en),
    .rst_rel      (core_rst_rel),
    .err          (cfg_err),
    .path         (last_path),
    .boot_exit_ev (boot_exit_ev),
    .wake_exit_ev (wake_exit_ev)
  );
endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk #(
  parameter int unsigned BOOT_CYCLES = 14
) (
  input logic       clk_main,
  input logic       por_n,
  input logic       rst_req,
  input logic       core_clk_en,
  input logic       core_rst_rel,
  input logic       cfg_err,
  input logic [1:0] last_path,
  input logic       wake_exit_ev
);
  timeunit 1ns; timeprecision 1ps;

  int unsigned hold_cnt;

  always_ff @(posedge clk_main or negedge por_n) begin
    if (!por_n)                      hold_cnt <= 0;
    else if (rst_req)                hold_cnt <= 0;
    else if (!core_rst_rel && hold_cnt < BOOT_CYCLES) hold_cnt <= hold_cnt + 1;
  end

  assert_clk_needs_release_R7: assert property (@(posedge clk_main) disable iff (!por_n)
    core_clk_en |-> core_rst_rel);

  assert_err_holds_core_R5: assert property (@(posedge clk_main) disable iff (!por_n)
    cfg_err |-> (!core_rst_rel && !core_clk_en));

  assert_restart_holds_R8: assert property (@(posedge clk_main) disable iff (!por_n)
    rst_req |=> (!core_rst_rel && !core_clk_en && !cfg_err));

  assert_min_boot_R2: assert property (@(posedge clk_main) disable iff (!por_n)
    $rose(core_rst_rel) |-> (hold_cnt >= BOOT_CYCLES));

  assert_wake_done_R7: assert property (@(posedge clk_main) disable iff (!por_n)
    (wake_exit_ev && !rst_req) |=> (core_clk_en && last_path == 2'b11));

  assert_path_sticky_R9: assert property (@(posedge clk_main) disable iff (!por_n)
    !$stable(last_path) |-> core_clk_en);
endmodule

bind sdseq_top sdseq_chk #(.BOOT_CYCLES(BOOT_CYCLES)) chk_i (
  .clk_main     (clk_main),
  .por_n        (por_n),
  .rst_req      (rst_req),
  .core_clk_en  (core_clk_en),
  .core_rst_rel (core_rst_rel),
  .cfg_err      (cfg_err),
  .last_path    (last_path),
  .wake_exit_ev (wake_exit_ev)
);

// File: tb/sdseq_top_tb_top.sv
module sdseq_top_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int SHORT = 6;
  localparam int LONG  = 20;
  localparam int RATIO = 7;   // slow period / main period

  localparam int P_BOOT = 0, P_SLOW = 1, P_RUN = 2, P_SLEEP = 3, P_WAKE = 4, P_HALT = 5;

  logic       clk_main = 1'b0;
  logic       clk_slow = 1'b0;
  logic       por_n, rst_req, deep_sleep;
  logic [1:0] sut;
  logic [3:0] cksel;
  logic       core_clk_en, core_rst_rel, cfg_err;
  logic [1:0] last_path;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  int ph = P_BOOT, mc = 0, ms = 0, mpath = 0, mtarget = 0;

  sdseq_top #(
    .BOOT_CYCLES (14),
    .WAKE_CYCLES (6),
    .SLOW_SHORT  (SHORT),
    .SLOW_LONG   (LONG)
  ) dut_i (
    .clk_main     (clk_main),
    .clk_slow     (clk_slow),
    .por_n        (por_n),
    .rst_req      (rst_req),
    .deep_sleep   (deep_sleep),
    .sut_code     (sut),
    .cksel_code   (cksel),
    .core_clk_en  (core_clk_en),
    .core_rst_rel (core_rst_rel),
    .cfg_err      (cfg_err),
    .last_path    (last_path)
  );

  initial forever #2.5  clk_main = ~clk_main;
  initial forever #17.5 clk_slow = ~clk_slow;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: stepped on each rising edge, compared 1 ns later.
  always @(posedge clk_main) begin
    if (!por_n) begin
      ph = P_BOOT; mc = 0; mpath = 0;
    end else if (rst_req) begin
      ph = P_BOOT; mc = 0;
    end else begin
      case (ph)
        P_BOOT: begin
          mc++;
          if (mc == 14) begin
            if (cksel != 4'b0000)  begin ph = P_RUN; mpath = 2; end
            else if (sut == 2'b00) begin ph = P_RUN; mpath = 1; end
            else if (sut == 2'b11) ph = P_HALT;
            else begin ph = P_SLOW; ms = 0; mtarget = (sut == 2'b01) ? SHORT : LONG; end
          end
        end
        P_SLOW:  ms++;
        P_RUN:   if (deep_sleep) ph = P_SLEEP;
        P_SLEEP: if (!deep_sleep) begin ph = P_WAKE; mc = 0; end
        P_WAKE: begin
          mc++;
          if (mc == 6) begin ph = P_RUN; mpath = 3; end
        end
        default: ;
      endcase
    end
    #1;
    if (ph == P_SLOW && (core_rst_rel || ms > (mtarget + 10) * RATIO)) begin
      chk(core_rst_rel && ms >= mtarget * RATIO && ms <= (mtarget + 10) * RATIO,
          {cur_tag, " slow delay window"}, ms, mtarget * RATIO);
      ph = P_RUN; mpath = 1;
    end
    begin
      int exp_v, act_v;
      exp_v = {28'd0, (ph == P_RUN), (ph == P_RUN || ph == P_SLEEP || ph == P_WAKE),
               (ph == P_HALT)} * 4 + mpath;
      act_v = {28'd0, core_clk_en, core_rst_rel, cfg_err} * 4 + int'(last_path);
      chk(act_v == exp_v, {cur_tag, " {en,rel,err,path}"}, act_v, exp_v);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_main);
  endtask

  task automatic pulse_rst();
    rst_req = 1'b1;
    tick(1);
    rst_req = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_req = 1'b0; deep_sleep = 1'b0; sut = 2'b00; cksel = 4'b0000;
    tick(6);
    cur_tag = "R1";
    chk({core_clk_en, core_rst_rel, cfg_err, last_path} == 5'b0, "R1 held in power-on",
        int'({core_clk_en, core_rst_rel, cfg_err, last_path}), 0);
    // R2: plain 14-cycle boot
    cur_tag = "R2"; por_n = 1'b1; tick(25);
    chk(last_path == 2'b01, "R2 path after table boot", int'(last_path), 1);
    // R7: sleep and 6-cycle wake
    cur_tag = "R7"; deep_sleep = 1'b1; tick(3); deep_sleep = 1'b0; tick(12);
    // R3: short slow delay, path stays wake until release (R9)
    cur_tag = "R3"; sut = 2'b01; pulse_rst(); tick(5);
    chk(last_path == 2'b11, "R9 path kept across reset", int'(last_path), 3);
    tick(200);
    // R4 with a sleep request (R10) and a restart (R8) inside the slow wait
    cur_tag = "R4"; sut = 2'b10; pulse_rst(); tick(40);
    cur_tag = "R10"; deep_sleep = 1'b1; tick(2); deep_sleep = 1'b0;
    cur_tag = "R8"; pulse_rst(); tick(300);
    // R5: reserved code
    cur_tag = "R5"; sut = 2'b11; pulse_rst(); tick(60);
    chk(cfg_err == 1'b1, "R5 error flag", int'(cfg_err), 1);
    deep_sleep = 1'b1; tick(3); deep_sleep = 1'b0; tick(20);
    chk(core_rst_rel == 1'b0, "R10 sleep ignored in error hold", int'(core_rst_rel), 0);
    // R6: bypass clock source with reserved code
    cur_tag = "R6"; cksel = 4'b0101; pulse_rst(); tick(20);
    chk(last_path == 2'b10 && !cfg_err, "R6 bypass path", int'(last_path), 2);
    // R8: restart in the middle of the main count
    cur_tag = "R8"; pulse_rst(); tick(7); pulse_rst(); tick(20);
    // R10: sleep held high across a whole boot
    cur_tag = "R10"; deep_sleep = 1'b1; pulse_rst(); tick(20); deep_sleep = 1'b0; tick(15);
    // R7: wake with a different start-up code
    cur_tag = "R7"; cksel = 4'b0000; sut = 2'b10; deep_sleep = 1'b1; tick(4);
    deep_sleep = 1'b0; tick(12);
    // R9: power-on clears the path status
    cur_tag = "R9"; por_n = 1'b0; tick(2);
    chk(last_path == 2'b00, "R9 path cleared by power-on", int'(last_path), 0);
    por_n = 1'b1; tick(20);
    finished = 1;
    summary();
    $finish;
  end
endmodule